// File: doc/BRIEF.md
# Hierarchical Interrupt Flag Controller

This block gathers the condition signals of a small power-management device (a set of buck converters, a set of linear regulators and a handful of device-wide monitors) and turns them into sticky interrupt flags. Every condition arrives as a synchronous level. The block works out the edges it needs, such as the start of a current-limit event or either direction of a power-good change. Each flag stays set until software writes a one to its bit. Some flags refuse that clear while their condition is still present.

Software reaches the block through a plain register port. It can read flags, masks, live status and two group summary bits, clear flags and program masks. A mask only stops a flag from pulling the active-low interrupt line; the flag itself is still recorded. Short-circuit, thermal-shutdown and overvoltage flags have no mask. The mask for the reset-event flag is captured from a strap input while reset is held, and writes cannot change it.

Top module: `irq_hub`

## Requirements
- R1: During and right after reset, every flag reads 0, every writable mask reads 0, the reset-event mask reads the value of `resetMaskDefault` sampled during reset, and `irqN` is 1.
- R2: The current-limit, short-circuit, thermal-warning, thermal-shutdown and overvoltage flags set on the clock edge where their condition input is first seen high. They stay set after the condition drops. In a regulator flag register, regulator i uses bit 3i for current limit, bit 3i+1 for short circuit and bit 3i+2 for power-good. In the device flag register, bit 0 is thermal warning, bit 1 thermal shutdown, bit 2 overvoltage, bit 3 measurement-ready and bit 4 reset event.
- R3: Writing 1 to a flag bit clears it on that edge. Writing 0 leaves it unchanged. The flag registers are at addresses 1 (bucks), 4 (linear regulators) and 7 (device).
- R4: A clear of a current-limit, thermal-warning, thermal-shutdown or overvoltage flag is ignored while the matching condition input is high.
- R5: When a clear and a new set event for the same flag fall on the same edge, the flag ends up set.
- R6: A regulator's power-good flag sets on both the rising and the falling change of its power-good input. In a regulator mask register, bit 3i masks current limit, bit 3i+1 masks the rising power-good change and bit 3i+2 masks the falling change, and each of the two change masks gates only its own direction.
- R7: A masked event still sets its flag and leaves `irqN` high. Masks are at address 2 (bucks), 5 (linear regulators) and 8 (device: bit 0 thermal warning, bit 3 measurement-ready, bit 4 reset event).
- R8: Short-circuit, thermal-shutdown and overvoltage flags drive `irqN` low whatever is written to any mask register.
- R9: Address 0 bit 0 is the OR of all pending buck flags and bit 1 is the OR of all pending linear-regulator flags, masked or not.
- R10: A high `measReady` sets a maskable flag (device bit 3). The device status register keeps its bit 3 at 0.
- R11: The reset-event flag sets while `resetEvent` is high. Its mask bit ignores register writes and only changes through reset.
- R12: `irqN` is 0 exactly when at least one flag is pending whose mask (or, for power-good, the mask of the direction that set it) is clear. It returns to 1 on the edge where the last such flag is cleared.
- R13: The status registers mirror the live inputs. At addresses 3 and 6, bit i is regulator i's current-limit input and bit N+i is its power-good input. At address 9, bits 0 to 2 are thermal warning, thermal shutdown and overvoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| buckIlim | input | NB | Buck current-limit levels |
| buckShort | input | NB | Buck short-circuit/overload levels |
| buckPgood | input | NB | Buck power-good levels |
| ldoIlim | input | NL | Linear regulator current-limit levels |
| ldoShort | input | NL | Linear regulator short-circuit levels |
| ldoPgood | input | NL | Linear regulator power-good levels |
| tempWarn | input | 1 | Die temperature warning level |
| tempShut | input | 1 | Die temperature shutdown level |
| overVolt | input | 1 | Supply overvoltage level |
| measReady | input | 1 | Load measurement finished |
| resetEvent | input | 1 | Start-up after a fault or software reset |
| resetMaskDefault | input | 1 | Strap value captured into the reset-event mask |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DW | Register write data |
| regRdData | output | DW | Register read data (combinational) |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with two bucks, two linear regulators and eight-bit registers. With these values the second regulator's bits land at positions 3 to 5, so any index slip between neighbouring regulators shows up in the flag and mask fields. The upper unused bits of each register also get written with ones, which exposes a stray bit. Directed sequences place a set event and a clear on the same edge, hold a clear against a live condition, and gate each power-good direction on its own. A long random phase then mixes toggling conditions with random clears and mask writes.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_SUMMARY   = 4'd0,
    SEL_BUCK_FLAG = 4'd1,
    SEL_BUCK_MASK = 4'd2,
    SEL_BUCK_STAT = 4'd3,
    SEL_LDO_FLAG  = 4'd4,
    SEL_LDO_MASK  = 4'd5,
    SEL_LDO_STAT  = 4'd6,
    SEL_TOP_FLAG  = 4'd7,
    SEL_TOP_MASK  = 4'd8,
    SEL_TOP_STAT  = 4'd9,
    SEL_NONE      = 4'd15
  } regSel_t;

  // strobes from decode to datapath
  typedef struct packed {
    logic    buckFlagClr;
    logic    buckMaskWr;
    logic    ldoFlagClr;
    logic    ldoMaskWr;
    logic    topFlagClr;
    logic    topMaskWr;
    regSel_t rdSel;
  } strobe_t;

  // device-level bit positions
  localparam int TOP_TWARN = 0;
  localparam int TOP_TSHUT = 1;
  localparam int TOP_OVP   = 2;
  localparam int TOP_MEAS  = 3;
  localparam int TOP_RESET = 4;
endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
  import irq_hub_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobe_t           strobe
);
  always_comb begin
    strobe             = '0;
    strobe.rdSel       = (regAddr <= 4'd9) ? regSel_t'(regAddr) : SEL_NONE;
    strobe.buckFlagClr = regWrEn && (regAddr == SEL_BUCK_FLAG);
    strobe.buckMaskWr  = regWrEn && (regAddr == SEL_BUCK_MASK);
    strobe.ldoFlagClr  = regWrEn && (regAddr == SEL_LDO_FLAG);
    strobe.ldoMaskWr   = regWrEn && (regAddr == SEL_LDO_MASK);
    strobe.topFlagClr  = regWrEn && (regAddr == SEL_TOP_FLAG);
    strobe.topMaskWr   = regWrEn && (regAddr == SEL_TOP_MASK);
  end
endmodule

// File: rtl/irq_hub_rail.sv
module irq_hub_rail #(
  parameter int N  = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  ilim,
  input  logic [N-1:0]  shortCkt,
  input  logic [N-1:0]  pgood,
  input  logic          flagClr,
  input  logic          maskWr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] flagReg,
  output logic [DW-1:0] maskReg,
  output logic [DW-1:0] statReg,
  output logic          anyPend,
  output logic          anyActive
);
  localparam int FW = 3 * N;

  logic [FW-1:0] flagVec;
  logic [FW-1:0] maskVec;
  logic [N-1:0]  actVec;

  for (genvar i = 0; i < N; i++) begin : gSlice
    logic ilimQ, shortQ, pgQ;
    logic ilimF, shortF, riseF, fallF;
    logic ilimM, riseM, fallM;
    logic clrIlim, clrShort, clrPg;

    assign clrIlim  = flagClr & wrData[3*i];
    assign clrShort = flagClr & wrData[3*i+1];
    assign clrPg    = flagClr & wrData[3*i+2];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ilimQ <= 1'b0; shortQ <= 1'b0; pgQ <= 1'b0;
        ilimF <= 1'b0; shortF <= 1'b0; riseF <= 1'b0; fallF <= 1'b0;
        ilimM <= 1'b0; riseM <= 1'b0; fallM <= 1'b0;
      end else begin
        ilimQ  <= ilim[i];
        shortQ <= shortCkt[i];
        pgQ    <= pgood[i];
        if (ilim[i] && !ilimQ)          ilimF <= 1'b1;
        else if (clrIlim && !ilim[i])   ilimF <= 1'b0;
        if (shortCkt[i] && !shortQ)     shortF <= 1'b1;
        else if (clrShort)              shortF <= 1'b0;
        if (pgood[i] && !pgQ)           riseF <= 1'b1;
        else if (clrPg)                 riseF <= 1'b0;
        if (!pgood[i] && pgQ)           fallF <= 1'b1;
        else if (clrPg)                 fallF <= 1'b0;
        if (maskWr) begin
          ilimM <= wrData[3*i];
          riseM <= wrData[3*i+1];
          fallM <= wrData[3*i+2];
        end
      end
    end

    assign flagVec[3*i +: 3] = {riseF | fallF, shortF, ilimF};
    assign maskVec[3*i +: 3] = {fallM, riseM, ilimM};
    assign actVec[i] = (ilimF & ~ilimM) | shortF | (riseF & ~riseM) | (fallF & ~fallM);
  end

  if (DW > FW) begin : gSpare
    logic unusedHighBits;
    assign unusedHighBits = ^wrData[DW-1:FW];
  end

  assign flagReg   = DW'(flagVec);
  assign maskReg   = DW'(maskVec);
  assign statReg   = DW'({pgood, ilim});
  assign anyPend   = |flagVec;
  assign anyActive = |actVec;
endmodule

// File: rtl/irq_hub_datapath.sv
module irq_hub_datapath
  import irq_hub_pkg::*;
#(
  parameter int NB = 2,
  parameter int NL = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic [DW-1:0] wrData,
  input  logic [NB-1:0] buckIlim,
  input  logic [NB-1:0] buckShort,
  input  logic [NB-1:0] buckPgood,
  input  logic [NL-1:0] ldoIlim,
  input  logic [NL-1:0] ldoShort,
  input  logic [NL-1:0] ldoPgood,
  input  logic          tempWarn,
  input  logic          tempShut,
  input  logic          overVolt,
  input  logic          measReady,
  input  logic          resetEvent,
  input  logic          resetMaskDefault,
  output logic [DW-1:0] rdData,
  output logic          irqN
);
  logic [DW-1:0] buckFlag, buckMask, buckStat, ldoFlag, ldoMask, ldoStat;
  logic buckPend, buckAct, ldoPend, ldoAct;

  irq_hub_rail #(.N(NB), .DW(DW)) uBuck (
    .clk(clk), .rstN(rstN), .ilim(buckIlim), .shortCkt(buckShort), .pgood(buckPgood),
    .flagClr(strobe.buckFlagClr), .maskWr(strobe.buckMaskWr), .wrData(wrData),
    .flagReg(buckFlag), .maskReg(buckMask), .statReg(buckStat),
    .anyPend(buckPend), .anyActive(buckAct));

  irq_hub_rail #(.N(NL), .DW(DW)) uLdo (
    .clk(clk), .rstN(rstN), .ilim(ldoIlim), .shortCkt(ldoShort), .pgood(ldoPgood),
    .flagClr(strobe.ldoFlagClr), .maskWr(strobe.ldoMaskWr), .wrData(wrData),
    .flagReg(ldoFlag), .maskReg(ldoMask), .statReg(ldoStat),
    .anyPend(ldoPend), .anyActive(ldoAct));

  // device-wide flags
  logic twQ, tsQ, ovQ;
  logic twF, tsF, ovF, meF, rsF;
  logic twM, meM, rsM;
  logic clrTw, clrTs, clrOv, clrMe, clrRs;
  logic topAct;
  logic unusedTopBits;

  assign clrTw = strobe.topFlagClr & wrData[TOP_TWARN];
  assign clrTs = strobe.topFlagClr & wrData[TOP_TSHUT];
  assign clrOv = strobe.topFlagClr & wrData[TOP_OVP];
  assign clrMe = strobe.topFlagClr & wrData[TOP_MEAS];
  assign clrRs = strobe.topFlagClr & wrData[TOP_RESET];
  assign unusedTopBits = ^wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      twQ <= 1'b0; tsQ <= 1'b0; ovQ <= 1'b0;
      twF <= 1'b0; tsF <= 1'b0; ovF <= 1'b0; meF <= 1'b0; rsF <= 1'b0;
      twM <= 1'b0; meM <= 1'b0;
      rsM <= resetMaskDefault;
    end else begin
      twQ <= tempWarn; tsQ <= tempShut; ovQ <= overVolt;
      if (tempWarn && !twQ)         twF <= 1'b1;
      else if (clrTw && !tempWarn)  twF <= 1'b0;
      if (tempShut && !tsQ)         tsF <= 1'b1;
      else if (clrTs && !tempShut)  tsF <= 1'b0;
      if (overVolt && !ovQ)         ovF <= 1'b1;
      else if (clrOv && !overVolt)  ovF <= 1'b0;
      if (measReady)                meF <= 1'b1;
      else if (clrMe)               meF <= 1'b0;
      if (resetEvent)               rsF <= 1'b1;
      else if (clrRs)               rsF <= 1'b0;
      if (strobe.topMaskWr) begin
        twM <= wrData[TOP_TWARN];
        meM <= wrData[TOP_MEAS];
      end
    end
  end

  assign topAct = (twF & ~twM) | tsF | ovF | (meF & ~meM) | (rsF & ~rsM);
  assign irqN   = ~(buckAct | ldoAct | topAct);

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      SEL_SUMMARY:   rdData = DW'({ldoPend, buckPend});
      SEL_BUCK_FLAG: rdData = buckFlag;
      SEL_BUCK_MASK: rdData = buckMask;
      SEL_BUCK_STAT: rdData = buckStat;
      SEL_LDO_FLAG:  rdData = ldoFlag;
      SEL_LDO_MASK:  rdData = ldoMask;
      SEL_LDO_STAT:  rdData = ldoStat;
      SEL_TOP_FLAG: begin
        rdData[TOP_TWARN] = twF;
        rdData[TOP_TSHUT] = tsF;
        rdData[TOP_OVP]   = ovF;
        rdData[TOP_MEAS]  = meF;
        rdData[TOP_RESET] = rsF;
      end
      SEL_TOP_MASK: begin
        rdData[TOP_TWARN] = twM;
        rdData[TOP_MEAS]  = meM;
        rdData[TOP_RESET] = rsM;
      end
      SEL_TOP_STAT: begin
        rdData[TOP_TWARN] = tempWarn;
        rdData[TOP_TSHUT] = tempShut;
        rdData[TOP_OVP]   = overVolt;
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NB = 2,
  parameter int NL = 2,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NB-1:0]     buckIlim,
  input  logic [NB-1:0]     buckShort,
  input  logic [NB-1:0]     buckPgood,
  input  logic [NL-1:0]     ldoIlim,
  input  logic [NL-1:0]     ldoShort,
  input  logic [NL-1:0]     ldoPgood,
  input  logic              tempWarn,
  input  logic              tempShut,
  input  logic              overVolt,
  input  logic              measReady,
  input  logic              resetEvent,
  input  logic              resetMaskDefault,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  output logic              irqN
);
  strobe_t strobe;

  irq_hub_decode uDecode (.regAddr(regAddr), .regWrEn(regWrEn), .strobe(strobe));

  irq_hub_datapath #(.NB(NB), .NL(NL), .DW(DW)) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .buckIlim(buckIlim), .buckShort(buckShort), .buckPgood(buckPgood),
    .ldoIlim(ldoIlim), .ldoShort(ldoShort), .ldoPgood(ldoPgood),
    .tempWarn(tempWarn), .tempShut(tempShut), .overVolt(overVolt),
    .measReady(measReady), .resetEvent(resetEvent),
    .resetMaskDefault(resetMaskDefault),
    .rdData(regRdData), .irqN(irqN));
endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker #(
  parameter int NB = 2,
  parameter int NL = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          irqN,
  input logic [NB-1:0] buckShort,
  input logic [NL-1:0] ldoShort,
  input logic          tempShut,
  input logic          overVolt
);
  logic rstLast = 1'b0;
  always_ff @(posedge clk) rstLast <= !rstN;

  // a reset edge leaves the request line released
  always @(posedge clk) begin
    if (rstLast) assert_reset_release_R1: assert (irqN);
  end

  assert_buck_short_unmaskable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|(buckShort & ~$past(buckShort))) |=> !irqN);

  assert_ldo_short_unmaskable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|(ldoShort & ~$past(ldoShort))) |=> !irqN);

  assert_tshut_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    tempShut |=> !irqN);

  assert_ovp_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    overVolt |=> !irqN);
endmodule

bind irq_hub irq_hub_checker #(.NB(NB), .NL(NL)) uChecker (
  .clk(clk), .rstN(rstN), .irqN(irqN), .buckShort(buckShort),
  .ldoShort(ldoShort), .tempShut(tempShut), .overVolt(overVolt));

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic [1:0] ilimIn [2];
  logic [1:0] shortIn [2];
  logic [1:0] pgIn [2];
  logic twIn, tsIn, ovIn, measIn, rsEvIn, rstMaskDefault;
  logic [3:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData, regRdData;
  logic       irqN;

  irq_hub #(.NB(2), .NL(2), .DW(8)) i_irq_hub (
    .clk(clk), .rstN(rstN),
    .buckIlim(ilimIn[0]), .buckShort(shortIn[0]), .buckPgood(pgIn[0]),
    .ldoIlim(ilimIn[1]), .ldoShort(shortIn[1]), .ldoPgood(pgIn[1]),
    .tempWarn(twIn), .tempShut(tsIn), .overVolt(ovIn),
    .measReady(measIn), .resetEvent(rsEvIn), .resetMaskDefault(rstMaskDefault),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqN(irqN));

  int nChk = 0, nFail = 0;
  bit done = 0;

  // reference model state, group 0 = bucks, group 1 = linear regulators
  logic [1:0] mIl [2], mSc [2], mPr [2], mPf [2], mIm [2], mRm [2], mFm [2];
  logic [1:0] pIl [2], pSc [2], pPg [2];
  logic mTw, mTs, mOv, mMe, mRs, mTwM, mMeM, mRsM, pTw, pTs, pOv;

  task automatic modelStep();
    logic [3:0] fa, ma;
    if (!rstN) begin
      for (int g = 0; g < 2; g++) begin
        mIl[g] = 0; mSc[g] = 0; mPr[g] = 0; mPf[g] = 0;
        mIm[g] = 0; mRm[g] = 0; mFm[g] = 0; pIl[g] = 0; pSc[g] = 0; pPg[g] = 0;
      end
      {mTw, mTs, mOv, mMe, mRs, mTwM, mMeM, pTw, pTs, pOv} = '0;
      mRsM = rstMaskDefault;
      return;
    end
    for (int g = 0; g < 2; g++) begin
      fa = (g == 0) ? 4'd1 : 4'd4;
      ma = (g == 0) ? 4'd2 : 4'd5;
      for (int i = 0; i < 2; i++) begin
        bit cI, cS, cP;
        cI = regWrEn && regAddr == fa && regWrData[3*i];
        cS = regWrEn && regAddr == fa && regWrData[3*i+1];
        cP = regWrEn && regAddr == fa && regWrData[3*i+2];
        if (ilimIn[g][i] && !pIl[g][i]) mIl[g][i] = 1; else if (cI && !ilimIn[g][i]) mIl[g][i] = 0;
        if (shortIn[g][i] && !pSc[g][i]) mSc[g][i] = 1; else if (cS) mSc[g][i] = 0;
        if (pgIn[g][i] && !pPg[g][i]) mPr[g][i] = 1; else if (cP) mPr[g][i] = 0;
        if (!pgIn[g][i] && pPg[g][i]) mPf[g][i] = 1; else if (cP) mPf[g][i] = 0;
        if (regWrEn && regAddr == ma) begin
          mIm[g][i] = regWrData[3*i]; mRm[g][i] = regWrData[3*i+1]; mFm[g][i] = regWrData[3*i+2];
        end
      end
      pIl[g] = ilimIn[g]; pSc[g] = shortIn[g]; pPg[g] = pgIn[g];
    end
    if (twIn && !pTw) mTw = 1; else if (regWrEn && regAddr == 7 && regWrData[0] && !twIn) mTw = 0;
    if (tsIn && !pTs) mTs = 1; else if (regWrEn && regAddr == 7 && regWrData[1] && !tsIn) mTs = 0;
    if (ovIn && !pOv) mOv = 1; else if (regWrEn && regAddr == 7 && regWrData[2] && !ovIn) mOv = 0;
    if (measIn) mMe = 1; else if (regWrEn && regAddr == 7 && regWrData[3]) mMe = 0;
    if (rsEvIn) mRs = 1; else if (regWrEn && regAddr == 7 && regWrData[4]) mRs = 0;
    if (regWrEn && regAddr == 8) begin mTwM = regWrData[0]; mMeM = regWrData[3]; end
    pTw = twIn; pTs = tsIn; pOv = ovIn;
  endtask

  function automatic logic grpPend(input int g);
    return |{mIl[g], mSc[g], mPr[g], mPf[g]};
  endfunction

  function automatic logic [7:0] expRead(input logic [3:0] a);
    logic [7:0] v;
    int g;
    v = '0;
    g = (a >= 4) ? 1 : 0;
    case (a)
      4'd0: v = {6'b0, grpPend(1), grpPend(0)};
      4'd1, 4'd4: for (int i = 0; i < 2; i++) begin
        v[3*i] = mIl[g][i]; v[3*i+1] = mSc[g][i]; v[3*i+2] = mPr[g][i] | mPf[g][i];
      end
      4'd2, 4'd5: for (int i = 0; i < 2; i++) begin
        v[3*i] = mIm[g][i]; v[3*i+1] = mRm[g][i]; v[3*i+2] = mFm[g][i];
      end
      4'd3, 4'd6: v = {4'b0, pgIn[g], ilimIn[g]};
      4'd7: v = {3'b0, mRs, mMe, mOv, mTs, mTw};
      4'd8: v = {3'b0, mRsM, mMeM, 2'b0, mTwM};
      4'd9: v = {5'b0, ovIn, tsIn, twIn};
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic expIrqN();
    logic act;
    act = 0;
    for (int g = 0; g < 2; g++)
      act |= |((mIl[g] & ~mIm[g]) | mSc[g] | (mPr[g] & ~mRm[g]) | (mPf[g] & ~mFm[g]));
    act |= (mTw & ~mTwM) | mTs | mOv | (mMe & ~mMeM) | (mRs & ~mRsM);
    return ~act;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a);
    regAddr = a; regWrEn = 0; #0.5;
    chk(tag, regRdData, expRead(a));
  endtask

  task automatic irqChk(input string tag);
    chk(tag, {7'b0, irqN}, {7'b0, expIrqN()});
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    tick();
    regWrEn = 0;
  endtask

  task automatic clearAll();
    wr(4'd1, 8'hFF); wr(4'd4, 8'hFF); wr(4'd7, 8'hFF);
  endtask

  task automatic doReset(input logic dflt);
    rstMaskDefault = dflt;
    rstN = 0;
    tick(); tick(); tick();
    rstN = 1;
    rstMaskDefault = 0;
  endtask

  initial begin
    int seedInit;
    seedInit = $urandom(32'd2024);
    for (int g = 0; g < 2; g++) begin ilimIn[g] = 0; shortIn[g] = 0; pgIn[g] = 0; end
    {twIn, tsIn, ovIn, measIn, rsEvIn, rstMaskDefault} = '0;
    regAddr = 0; regWrEn = 0; regWrData = 0;
    @(negedge clk);
    doReset(1'b0);

    // reset state
    irqChk("R1 irq after reset");
    chk("R1 irq released", {7'b0, irqN}, 8'h01);
    for (int a = 0; a < 10; a++) rdChk("R1 register reset value", 4'(a));

    // masked current limit still records, sticky after drop
    wr(4'd2, 8'h01);
    ilimIn[0] = 2'b01; tick(); ilimIn[0] = 2'b00; tick();
    rdChk("R2 sticky current-limit flag", 4'd1);
    chk("R7 masked flag leaves irq high", {7'b0, irqN}, 8'h01);
    wr(4'd1, 8'h01);
    rdChk("R3 current-limit flag cleared", 4'd1);

    // clear refused while thermal warning active
    twIn = 1; tick();
    wr(4'd7, 8'h01);
    rdChk("R4 warning clear ignored while active", 4'd7);
    chk("R4 irq still low", {7'b0, irqN}, 8'h00);
    rdChk("R13 device status live", 4'd9);
    twIn = 0; tick();
    wr(4'd7, 8'h01);
    rdChk("R3 warning cleared once inactive", 4'd7);

    // write zero has no effect, no status bit for measurement
    measIn = 1; tick();
    rdChk("R10 measurement has no status bit", 4'd9);
    measIn = 0;
    wr(4'd7, 8'h00);
    rdChk("R3 writing zero keeps flag", 4'd7);
    clearAll();

    // set wins over same-cycle clear
    shortIn[0] = 2'b10;
    wr(4'd1, 8'h10);
    rdChk("R5 set beats clear", 4'd1);
    shortIn[0] = 2'b00; tick();
    rdChk("R9 buck group summary set", 4'd0);
    clearAll();
    rdChk("R9 summary cleared", 4'd0);

    // power-good directions
    wr(4'd5, 8'h02);
    pgIn[1] = 2'b01; tick();
    rdChk("R6 rising power-good flag", 4'd4);
    chk("R6 rising masked keeps irq high", {7'b0, irqN}, 8'h01);
    rdChk("R13 ldo power-good status", 4'd6);
    rdChk("R9 ldo group summary", 4'd0);
    pgIn[1] = 2'b00; tick();
    chk("R6 falling unmasked pulls irq", {7'b0, irqN}, 8'h00);
    wr(4'd4, 8'h04);
    chk("R12 released after clear", {7'b0, irqN}, 8'h01);

    // unmaskable flags
    wr(4'd2, 8'hFF); wr(4'd5, 8'hFF); wr(4'd8, 8'hFF);
    ovIn = 1; tick();
    chk("R8 overvoltage ignores masks", {7'b0, irqN}, 8'h00);
    ovIn = 0; tick(); wr(4'd7, 8'hFF);
    shortIn[1] = 2'b01; tick(); shortIn[1] = 2'b00; tick();
    chk("R8 short circuit ignores masks", {7'b0, irqN}, 8'h00);
    clearAll();
    chk("R12 release after full clear", {7'b0, irqN}, 8'h01);

    // measurement maskable
    measIn = 1; tick(); measIn = 0;
    chk("R10 masked measurement irq high", {7'b0, irqN}, 8'h01);
    rdChk("R10 measurement flag set", 4'd7);
    wr(4'd8, 8'h00);
    chk("R10 unmasked measurement pulls irq", {7'b0, irqN}, 8'h00);
    clearAll();

    // reset-event mask
    wr(4'd8, 8'h10);
    rdChk("R11 mask write ignored", 4'd8);
    rsEvIn = 1; tick(); rsEvIn = 0;
    chk("R11 unmasked reset event", {7'b0, irqN}, 8'h00);
    clearAll();
    doReset(1'b1);
    rdChk("R1 mask loaded from default", 4'd8);
    wr(4'd8, 8'h00);
    rdChk("R11 mask kept after write", 4'd8);
    rsEvIn = 1; tick(); rsEvIn = 0;
    chk("R11 default mask holds irq high", {7'b0, irqN}, 8'h01);
    rdChk("R11 reset flag set", 4'd7);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int k;
      for (int g = 0; g < 2; g++)
        for (int i = 0; i < 2; i++) begin
          if ($urandom % 8 == 0) ilimIn[g][i] = ~ilimIn[g][i];
          if ($urandom % 12 == 0) shortIn[g][i] = ~shortIn[g][i];
          if ($urandom % 8 == 0) pgIn[g][i] = ~pgIn[g][i];
        end
      if ($urandom % 10 == 0) twIn = ~twIn;
      if ($urandom % 14 == 0) tsIn = ~tsIn;
      if ($urandom % 14 == 0) ovIn = ~ovIn;
      measIn = ($urandom % 16 == 0);
      rsEvIn = ($urandom % 32 == 0);
      k = $urandom % 12;
      regWrData = 8'($urandom);
      if (k < 4) begin
        regWrEn = 1; regAddr = (k == 0) ? 4'd1 : (k == 1) ? 4'd4 : 4'd7;
      end else if (k == 4) begin
        regWrEn = 1; regWrData = 8'($urandom & $urandom);
        regAddr = 4'd2 + 4'(3 * ($urandom % 3));
      end
      tick();
      regWrEn = 0;
      irqChk("R12 random irq level");
      rdChk("R3 random register read", 4'($urandom % 16));
      if (n % 64 == 63) begin
        for (int g = 0; g < 2; g++) begin ilimIn[g] = 0; shortIn[g] = 0; pgIn[g] = 0; end
        {twIn, tsIn, ovIn, measIn, rsEvIn} = '0;
        tick(); clearAll();
        chk("R12 release after quiet clear", {7'b0, irqN}, 8'h01);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule